// File: doc/BRIEF.md
# CAN Error Status Capture Unit

This block keeps the error-management state of a CAN controller and exposes it through a small byte-wide register interface. It holds a transmit error counter, a receive error counter and a programmable warning limit. It also has two capture registers: one for the code of a bus error and one for the identifier bit index at which arbitration was lost. A protocol engine drives it with single-cycle event strobes, and a host reads and writes it through a simple address/data port.

Each capture register takes the first event that arrives and then locks. Later events are ignored until the host reads the register. That read re-arms the register and clears the matching status flag. The host can write the counters only while the controller is held in reset mode. Entering bus-off forces the transmit counter to 128 and clears the receive counter. A warning output and two interrupt outputs summarise the state for the surrounding controller.

Register addresses (`regAddr`): 0 transmit counter, 1 receive counter, 2 warning limit, 3 error-code capture, 4 arbitration-lost capture, 5 control. The control register holds bit 0 for the bus-error interrupt enable, bit 1 for the arbitration-lost interrupt enable, bit 2 for the bus-error flag (read-only) and bit 3 for the arbitration-lost flag (read-only). Its bits 7:4 read as zero. Read data is combinational from the addressed register. Every register update, including the clear caused by a read (`rdEn` high), takes effect at the next rising clock edge.

Top module: `can_err_status`

## Requirements
- R1: After reset, both error counters read 0, the warning limit reads 0x60, both capture registers read 0 and the control register reads 0.
- R2: A host write to address 0 or 1 loads that counter only while `resetMode` is high. When `resetMode` is low, the write leaves the counter unchanged.
- R3: One cycle after `busOffStb`, the transmit counter reads 128 and the receive counter reads 0. Bus-off takes priority over writes and count requests in the same cycle.
- R4: Increment and decrement strobes change a counter by one, saturating at 255 and at 0. They have no effect while `resetMode` is high, and an increment together with a decrement leaves the counter unchanged.
- R5: `warnOut` is high exactly when the transmit counter or the receive counter is greater than or equal to the warning limit.
- R6: When unlocked, `busErrStb` stores `busErrCode` at address 3 and sets the bus-error flag (control bit 2). While the flag is set, further bus errors leave address 3 unchanged. A host read of address 3 clears the flag.
- R7: When unlocked, `arbLostStb` stores `arbLostBit` in bits 4:0 of address 4, with bits 7:5 reading zero, and sets the arbitration-lost flag (control bit 3). While the flag is set, the value holds. A host read of address 4 clears the flag.
- R8: If a host read of a capture register and a new event for it occur in the same cycle, the read returns the old value. The new value is then captured and the flag stays set.
- R9: `busErrIrq` equals the bus-error flag AND control bit 0. `arbLostIrq` equals the arbitration-lost flag AND control bit 1.
- R10: The warning limit at address 2 can be written whether or not `resetMode` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| resetMode | input | 1 | Controller held in reset mode |
| regAddr | input | 3 | Host register address |
| wrEn | input | 1 | Host write strobe |
| wrData | input | 8 | Host write data |
| rdEn | input | 1 | Host read strobe (clears capture flags) |
| rdData | output | 8 | Host read data |
| busErrStb | input | 1 | Bus error event |
| busErrCode | input | 8 | Bus error code |
| arbLostStb | input | 1 | Arbitration lost event |
| arbLostBit | input | 5 | Identifier bit index of lost arbitration |
| busOffStb | input | 1 | Bus-off entry event |
| txIncStb | input | 1 | Transmit counter increment request |
| txDecStb | input | 1 | Transmit counter decrement request |
| rxIncStb | input | 1 | Receive counter increment request |
| rxDecStb | input | 1 | Receive counter decrement request |
| warnOut | output | 1 | A counter is at or above the warning limit |
| busErrIrq | output | 1 | Bus-error interrupt |
| arbLostIrq | output | 1 | Arbitration-lost interrupt |

## Verification
The hardest case to reach is a capture read that lands in the same clock as a fresh event for that register. The bench sets this up in stages. It first fills the register so that it is locked. Then, on one falling edge, it raises the read strobe and the event strobe together, with a different code. It samples the read data before the rising edge to see the old code. Finally it reads the register again and checks that the new code was taken and that the flag is still set. Counter saturation is reached by writing a value next to the limit while in reset mode, leaving reset mode, and then pulsing the count strobes.

// File: rtl/can_err_pkg.sv
package can_err_pkg;
  localparam logic [2:0] ADDR_TX  = 3'd0;
  localparam logic [2:0] ADDR_RX  = 3'd1;
  localparam logic [2:0] ADDR_LIM = 3'd2;
  localparam logic [2:0] ADDR_ECC = 3'd3;
  localparam logic [2:0] ADDR_ALC = 3'd4;
  localparam logic [2:0] ADDR_CTL = 3'd5;

  typedef struct packed {
    logic wrTx;
    logic wrRx;
    logic wrLim;
    logic txUp;
    logic txDn;
    logic rxUp;
    logic rxDn;
    logic busOff;
    logic capEcc;
    logic capAlc;
  } dpCmdS;
endpackage

// File: rtl/can_err_ctrl.sv
module can_err_ctrl
  import can_err_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       resetMode,
  input  logic [2:0] regAddr,
  input  logic       wrEn,
  input  logic [1:0] enBits,
  input  logic       rdEn,
  input  logic       busErrStb,
  input  logic       arbLostStb,
  input  logic       busOffStb,
  input  logic       txIncStb,
  input  logic       txDecStb,
  input  logic       rxIncStb,
  input  logic       rxDecStb,
  output dpCmdS      cmd,
  output logic       errFlag,
  output logic       arbFlag,
  output logic       errEn,
  output logic       arbEn,
  output logic       busErrIrq,
  output logic       arbLostIrq
);
  logic rdEcc, rdAlc, wrCtl;

  assign rdEcc = rdEn && (regAddr == ADDR_ECC);
  assign rdAlc = rdEn && (regAddr == ADDR_ALC);
  assign wrCtl = wrEn && (regAddr == ADDR_CTL);

  always_comb begin
    cmd        = '0;
    cmd.wrTx   = wrEn && (regAddr == ADDR_TX) && resetMode;
    cmd.wrRx   = wrEn && (regAddr == ADDR_RX) && resetMode;
    cmd.wrLim  = wrEn && (regAddr == ADDR_LIM);
    cmd.txUp   = txIncStb && !resetMode;
    cmd.txDn   = txDecStb && !resetMode;
    cmd.rxUp   = rxIncStb && !resetMode;
    cmd.rxDn   = rxDecStb && !resetMode;
    cmd.busOff = busOffStb;
    cmd.capEcc = busErrStb && (!errFlag || rdEcc);
    cmd.capAlc = arbLostStb && (!arbFlag || rdAlc);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag <= 1'b0;
      arbFlag <= 1'b0;
      errEn   <= 1'b0;
      arbEn   <= 1'b0;
    end else begin
      if (cmd.capEcc)      errFlag <= 1'b1;
      else if (rdEcc)      errFlag <= 1'b0;
      if (cmd.capAlc)      arbFlag <= 1'b1;
      else if (rdAlc)      arbFlag <= 1'b0;
      if (wrCtl) begin
        errEn <= enBits[0];
        arbEn <= enBits[1];
      end
    end
  end

  assign busErrIrq  = errFlag && errEn;
  assign arbLostIrq = arbFlag && arbEn;

  // R6: a read of the code register with no new error leaves the interrupt low
  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdEcc && !busErrStb) |=> !busErrIrq);
  // R7: the same holds for the arbitration-lost register
  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdAlc && !arbLostStb) |=> !arbLostIrq);
endmodule

// File: rtl/can_err_dp.sv
module can_err_dp
  import can_err_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ALC_W     = 5,
  parameter int LIMIT_RST = 96,
  parameter int BUSOFF_TX = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmdS             cmd,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] errCode,
  input  logic [ALC_W-1:0]  arbBit,
  output logic [DATA_W-1:0] txCnt,
  output logic [DATA_W-1:0] rxCnt,
  output logic [DATA_W-1:0] limitVal,
  output logic [DATA_W-1:0] eccVal,
  output logic [DATA_W-1:0] alcVal,
  output logic              warn
);
  localparam int NCNT = 2;
  localparam logic [DATA_W-1:0] CNT_MAX = '1;

  logic [DATA_W-1:0] cnt   [NCNT];
  logic              cntWr [NCNT];
  logic              cntUp [NCNT];
  logic              cntDn [NCNT];

  assign cntWr[0] = cmd.wrTx;  assign cntWr[1] = cmd.wrRx;
  assign cntUp[0] = cmd.txUp;  assign cntUp[1] = cmd.rxUp;
  assign cntDn[0] = cmd.txDn;  assign cntDn[1] = cmd.rxDn;

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    localparam logic [DATA_W-1:0] OFF_VAL = (i == 0) ? DATA_W'(BUSOFF_TX) : '0;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                   cnt[i] <= '0;
      else if (cmd.busOff)                         cnt[i] <= OFF_VAL;
      else if (cntWr[i])                           cnt[i] <= wrData;
      else if (cntUp[i] && !cntDn[i] && cnt[i] != CNT_MAX) cnt[i] <= cnt[i] + 1'b1;
      else if (cntDn[i] && !cntUp[i] && cnt[i] != '0)      cnt[i] <= cnt[i] - 1'b1;
    end
  end

  assign txCnt = cnt[0];
  assign rxCnt = cnt[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      limitVal <= DATA_W'(LIMIT_RST);
      eccVal   <= '0;
      alcVal   <= '0;
    end else begin
      if (cmd.wrLim)  limitVal <= wrData;
      if (cmd.capEcc) eccVal   <= errCode;
      if (cmd.capAlc) alcVal   <= DATA_W'(arbBit);
    end
  end

  assign warn = (txCnt >= limitVal) || (rxCnt >= limitVal);

  // R3: bus-off presets the counters
  p_bus_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.busOff |=> (txCnt == DATA_W'(BUSOFF_TX)) && (rxCnt == '0));
  // R4: saturation at the top
  p_sat_hi_r4: assert property (@(posedge clk) disable iff (!rstN)
    (txCnt == CNT_MAX && cmd.txUp && !cmd.busOff && !cmd.wrTx) |=> txCnt == CNT_MAX);
  // R4: saturation at the bottom
  p_sat_lo_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rxCnt == '0 && cmd.rxDn && !cmd.busOff && !cmd.wrRx) |=> rxCnt == '0);
endmodule

// File: rtl/can_err_status.sv
module can_err_status
  import can_err_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ALC_W     = 5,
  parameter int LIMIT_RST = 96,
  parameter int BUSOFF_TX = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resetMode,
  input  logic [2:0]        regAddr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  input  logic              busErrStb,
  input  logic [DATA_W-1:0] busErrCode,
  input  logic              arbLostStb,
  input  logic [ALC_W-1:0]  arbLostBit,
  input  logic              busOffStb,
  input  logic              txIncStb,
  input  logic              txDecStb,
  input  logic              rxIncStb,
  input  logic              rxDecStb,
  output logic              warnOut,
  output logic              busErrIrq,
  output logic              arbLostIrq
);
  dpCmdS cmd;
  logic errFlag, arbFlag, errEn, arbEn;
  logic [DATA_W-1:0] txCnt, rxCnt, limitVal, eccVal, alcVal;

  can_err_ctrl u_ctrl (
    .clk, .rstN, .resetMode, .regAddr, .wrEn,
    .enBits(wrData[1:0]), .rdEn, .busErrStb, .arbLostStb, .busOffStb,
    .txIncStb, .txDecStb, .rxIncStb, .rxDecStb,
    .cmd, .errFlag, .arbFlag, .errEn, .arbEn, .busErrIrq, .arbLostIrq
  );

  can_err_dp #(.DATA_W(DATA_W), .ALC_W(ALC_W), .LIMIT_RST(LIMIT_RST), .BUSOFF_TX(BUSOFF_TX)) u_dp (
    .clk, .rstN, .cmd, .wrData, .errCode(busErrCode), .arbBit(arbLostBit),
    .txCnt, .rxCnt, .limitVal, .eccVal, .alcVal, .warn(warnOut)
  );

  always_comb begin
    unique case (regAddr)
      ADDR_TX:  rdData = txCnt;
      ADDR_RX:  rdData = rxCnt;
      ADDR_LIM: rdData = limitVal;
      ADDR_ECC: rdData = eccVal;
      ADDR_ALC: rdData = alcVal;
      ADDR_CTL: rdData = DATA_W'({arbFlag, errFlag, arbEn, errEn});
      default:  rdData = '0;
    endcase
  end

  // R2: counter writes outside reset mode are dropped
  p_write_blocked_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == ADDR_TX && !resetMode && !busOffStb && !txIncStb && !txDecStb)
      |=> txCnt == $past(txCnt));
  // R6: a locked code register keeps its value until read
  p_hold_first_r6: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !(rdEn && regAddr == ADDR_ECC)) |=> $stable(eccVal));
  // R8: read and new error together capture the new code
  p_rearm_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regAddr == ADDR_ECC && busErrStb) |=> errFlag && eccVal == $past(busErrCode));
  // R7: upper bits of the arbitration-lost register read zero
  p_alc_upper_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_ALC) |-> rdData[DATA_W-1:ALC_W] == '0);
endmodule

// File: tb/tb_can_err_status.sv
module tb_can_err_status;
  logic clk = 0, rstN = 0, resetMode = 0;
  logic [2:0] regAddr = 0;
  logic wrEn = 0, rdEn = 0;
  logic [7:0] wrData = 0, rdData, busErrCode = 0;
  logic busErrStb = 0, arbLostStb = 0, busOffStb = 0;
  logic [4:0] arbLostBit = 0;
  logic txIncStb = 0, txDecStb = 0, rxIncStb = 0, rxDecStb = 0;
  logic warnOut, busErrIrq, arbLostIrq;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  can_err_status dut (.*);

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic hostWr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); regAddr = a; wrData = d; wrEn = 1;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic hostRd(logic [2:0] a, output logic [7:0] v);
    @(negedge clk); regAddr = a; rdEn = 1; #1 v = rdData;
    @(negedge clk); rdEn = 0;
  endtask

  task automatic pulseErr(logic [7:0] c);
    @(negedge clk); busErrCode = c; busErrStb = 1;
    @(negedge clk); busErrStb = 0;
  endtask

  task automatic pulseArb(logic [4:0] b);
    @(negedge clk); arbLostBit = b; arbLostStb = 1;
    @(negedge clk); arbLostStb = 0;
  endtask

  task automatic tReset();
    logic [7:0] v;
    hostRd(0, v); chk("R1 tx", v, 0);
    hostRd(1, v); chk("R1 rx", v, 0);
    hostRd(2, v); chk("R1 limit", v, 8'h60);
    hostRd(3, v); chk("R1 ecc", v, 0);
    hostRd(4, v); chk("R1 alc", v, 0);
    hostRd(5, v); chk("R1 ctl", v, 0);
  endtask

  task automatic tCounterWrite();
    logic [7:0] v;
    resetMode = 1; hostWr(0, 8'h21); hostWr(1, 8'h34);
    hostRd(0, v); chk("R2 tx in reset mode", v, 8'h21);
    hostRd(1, v); chk("R2 rx in reset mode", v, 8'h34);
    resetMode = 0; hostWr(0, 8'h77); hostWr(1, 8'h66);
    hostRd(0, v); chk("R2 tx write ignored", v, 8'h21);
    hostRd(1, v); chk("R2 rx write ignored", v, 8'h34);
  endtask

  task automatic tBusOff();
    logic [7:0] v;
    @(negedge clk); busOffStb = 1; txIncStb = 1; rxIncStb = 1;
    @(negedge clk); busOffStb = 0; txIncStb = 0; rxIncStb = 0;
    hostRd(0, v); chk("R3 tx bus-off", v, 8'd128);
    hostRd(1, v); chk("R3 rx bus-off", v, 0);
  endtask

  task automatic tSaturate();
    logic [7:0] v;
    resetMode = 1; hostWr(0, 8'hFE); hostWr(1, 8'h01);
    @(negedge clk); txIncStb = 1; rxDecStb = 1;
    @(negedge clk); txIncStb = 0; rxDecStb = 0;
    hostRd(0, v); chk("R4 inc ignored in reset mode", v, 8'hFE);
    resetMode = 0;
    repeat (3) begin
      @(negedge clk); txIncStb = 1; rxDecStb = 1;
      @(negedge clk); txIncStb = 0; rxDecStb = 0;
    end
    hostRd(0, v); chk("R4 tx saturates 255", v, 8'hFF);
    hostRd(1, v); chk("R4 rx saturates 0", v, 0);
    @(negedge clk); txIncStb = 1; txDecStb = 1;
    @(negedge clk); txIncStb = 0; txDecStb = 0;
    hostRd(0, v); chk("R4 inc+dec no change", v, 8'hFF);
    @(negedge clk); txDecStb = 1;
    @(negedge clk); txDecStb = 0;
    hostRd(0, v); chk("R4 tx dec", v, 8'hFE);
  endtask

  task automatic tWarn();
    resetMode = 1; hostWr(0, 8'h5F); hostWr(1, 8'h00);
    chk("R5 warn below", {7'b0, warnOut}, 0);
    hostWr(1, 8'h60);
    chk("R5 warn rx equal", {7'b0, warnOut}, 1);
    hostWr(1, 8'h00); hostWr(0, 8'h60);
    chk("R5 warn tx equal", {7'b0, warnOut}, 1);
    resetMode = 0;
    hostWr(2, 8'h61);
    chk("R10 limit written outside reset mode", {7'b0, warnOut}, 0);
    hostWr(2, 8'h60);
    chk("R5 warn restored", {7'b0, warnOut}, 1);
  endtask

  task automatic tEccLock();
    logic [7:0] v;
    pulseErr(8'hA5); pulseErr(8'h3C);
    hostRd(5, v); chk("R6 flag set", v & 8'h04, 8'h04);
    hostRd(3, v); chk("R6 first code held", v, 8'hA5);
    hostRd(5, v); chk("R6 flag cleared by read", v & 8'h04, 0);
    pulseErr(8'h3C);
    hostRd(3, v); chk("R6 rearmed capture", v, 8'h3C);
  endtask

  task automatic tAlc();
    logic [7:0] v;
    pulseArb(5'h1F); pulseArb(5'h02);
    hostRd(5, v); chk("R7 flag set", v & 8'h08, 8'h08);
    hostRd(4, v); chk("R7 bit held, upper zero", v, 8'h1F);
    hostRd(5, v); chk("R7 flag cleared", v & 8'h08, 0);
    pulseArb(5'h02);
    hostRd(4, v); chk("R7 rearmed capture", v, 8'h02);
  endtask

  task automatic tSameCycle();
    logic [7:0] v;
    pulseErr(8'h11);
    @(negedge clk); regAddr = 3; rdEn = 1; busErrCode = 8'h22; busErrStb = 1;
    #1 chk("R8 read returns old code", rdData, 8'h11);
    @(negedge clk); rdEn = 0; busErrStb = 0;
    hostRd(5, v); chk("R8 flag still set", v & 8'h04, 8'h04);
    hostRd(3, v); chk("R8 new code captured", v, 8'h22);
  endtask

  task automatic tIrq();
    logic [7:0] v;
    hostWr(5, 8'h01);
    pulseErr(8'h44); pulseArb(5'h07);
    chk("R9 bus-error irq enabled", {7'b0, busErrIrq}, 1);
    chk("R9 arb irq masked", {7'b0, arbLostIrq}, 0);
    hostWr(5, 8'h02);
    chk("R9 bus-error irq masked", {7'b0, busErrIrq}, 0);
    chk("R9 arb irq enabled", {7'b0, arbLostIrq}, 1);
    hostRd(4, v);
    chk("R9 arb irq cleared by read", {7'b0, arbLostIrq}, 0);
    hostRd(3, v);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    tReset();
    tCounterWrite();
    tBusOff();
    tSaturate();
    tWarn();
    tEccLock();
    tAlc();
    tSameCycle();
    tIrq();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule